// File: doc/BRIEF.md
# Slot Buffer Controller

This block steers a first-in-first-out packet buffer made of `SLOTS` equal slots, each of which holds exactly one packet for a fixed residence time of `SLOT_TIME` cycles. Several such buffering modules share one output. Each module runs its own copy of this controller, and the copies coordinate only through a single busy line per module. The controller receives a one-cycle pulse when the start of a packet is detected. From these pulses and from its own residence timing it keeps a one-hot position pointer that tells the packet switch which slot the arriving packet goes to. The pointer's extra top line tells the switch to drop the data, because every slot is already taken.

When the packet at the head of the queue has stayed `SLOT_TIME` cycles, the controller starts a forward phase. A forward can only start while no other module reports that it is busy. A forward moves every stored packet one slot toward the output and lowers the pointer by one. The forward level and the busy output then stay high for exactly `SLOT_TIME` cycles. A forward that is held back by another module is tried again on every cycle until the shared output is free. An end-of-packet pulse is accepted at the port but has no effect.

Top module: `slot_buf_ctrl`

## Requirements
- R1: While `rst_n` is low, `store_o` is all zeros and `fwd_o` and `busy_o` are low, whatever the other inputs do.
- R2: At most one bit of `store_o` is set. Bit i means the arriving packet goes to slot i+1, bit `SLOTS` means discard, and all zeros means the buffer is empty.
- R3: A `sop_i` sampled at an edge with no forward start at that edge moves the set bit up by one: empty goes to bit 0, bit i goes to bit i+1, and bit `SLOTS` stays set.
- R4: A forward start with no `sop_i` at the same edge moves the set bit down by one, and bit 0 goes to empty.
- R5: A packet that arrives at edge e into an empty buffer, with no peer busy and no forward active, starts a forward at edge e+SLOT_TIME+1. `fwd_o` is then high when sampled after that edge.
- R6: Once raised, `fwd_o` stays high for exactly `SLOT_TIME` consecutive cycles, and no new forward starts while it is high.
- R7: `busy_o` equals `fwd_o` on every cycle.
- R8: While any bit of `peer_busy_i` is high, no forward starts. A forward that is ready starts at the first edge that samples all of `peer_busy_i` low.
- R9: When a `sop_i` and a forward start fall on the same edge, `store_o` does not change.
- R10: `eop_i` has no effect on `store_o`, `fwd_o` or the forward timing.
- R11: A packet behind the head keeps ageing while it waits. If it has already aged `SLOT_TIME` cycles, its forward starts one cycle after the previous forward ends, that is, at the edge after the first edge that samples `fwd_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sop_i | input | 1 | One-cycle pulse: start of an incoming packet detected |
| eop_i | input | 1 | One-cycle pulse: end of packet detected (no effect) |
| peer_busy_i | input | MODULES-1 | Busy lines of the other modules, one per module |
| store_o | output | SLOTS+1 | One-hot slot pointer; top bit means discard |
| fwd_o | output | 1 | High for SLOT_TIME cycles per forward |
| busy_o | output | 1 | Busy line sent to the other modules |

## Verification
The properties assume that `sop_i` comes as single-cycle pulses at packet starts, and that `peer_busy_i` comes from registered outputs of the other modules, so it does not depend on this module's own forward decision in the same cycle. They also assume that packets are no longer than `SLOT_TIME`, which the controller cannot observe. The stimulus drives `sop_i` and `eop_i` as isolated pulses. It drives `peer_busy_i` in random bursts that are freer than real peers would produce, so the hold-and-retry path is exercised harder than in use. Directed sequences line up an arrival with a forward start, fill the buffer past the discard line while the peers hold the output, and drain a queue whose packets have already aged.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;

  // Width of a counter that must hold every value 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/sbc_store_ptr.sv
`timescale 1ns/1ps
// One-hot slot pointer: up on arrival, down on forward, unchanged on both.
module sbc_store_ptr #(
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arrive_i,
  input  logic             depart_i,
  output logic [SLOTS:0]   ptr_o,
  output logic [SLOTS:0]   ptr_next_o
);

  localparam int unsigned LINES = SLOTS + 1;

  logic [SLOTS:0] ptr_q;
  logic [SLOTS:0] ptr_d;
  logic [SLOTS:0] ptr_up;
  logic [SLOTS:0] ptr_down;
  logic           ptr_en;

  always_comb begin
    if (ptr_q == '0) begin
      ptr_up = LINES'(1);
    end else if (ptr_q[SLOTS]) begin
      ptr_up = ptr_q;
    end else begin
      ptr_up = ptr_q << 1;
    end
    ptr_down = ptr_q >> 1;
  end

  always_comb begin
    ptr_en = arrive_i ^ depart_i;
    ptr_d  = ptr_q;
    if (arrive_i && !depart_i) begin
      ptr_d = ptr_up;
    end else if (depart_i && !arrive_i) begin
      ptr_d = ptr_down;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o      = ptr_q;
  assign ptr_next_o = ptr_d;

endmodule

// File: rtl/sbc_age_track.sv
`timescale 1ns/1ps
// Residence age per slot; ages move with the packets on a forward.
module sbc_age_track #(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned SLOT_TIME = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arrive_i,
  input  logic             depart_i,
  input  logic [SLOTS:0]   ptr_i,
  input  logic [SLOTS:0]   ptr_next_i,
  output logic             head_ready_o
);

  localparam int unsigned AW = sbc_pkg::cnt_width(SLOT_TIME);
  localparam logic [AW-1:0] AGE_MAX = AW'(SLOT_TIME);

  logic [AW-1:0] age_q [SLOTS];
  logic [AW-1:0] age_d [SLOTS];
  logic [SLOTS-1:0] age_en;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [AW-1:0] shift_in;
    logic [AW-1:0] base;
    logic          occ_next;
    logic          lands;

    if (k == SLOTS - 1) begin : g_top
      assign shift_in = '0;
    end else begin : g_mid
      assign shift_in = age_q[k+1];
    end

    always_comb begin
      base     = depart_i ? shift_in : age_q[k];
      occ_next = |ptr_next_i[SLOTS:k];
      lands    = arrive_i && ptr_next_i[k];
      if (!occ_next || lands) begin
        age_d[k] = '0;
      end else if (base == AGE_MAX) begin
        age_d[k] = base;
      end else begin
        age_d[k] = base + AW'(1);
      end
      age_en[k] = occ_next || (age_q[k] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[k] <= '0;
      end else if (age_en[k]) begin
        age_q[k] <= age_d[k];
      end
    end
  end

  assign head_ready_o = (|ptr_i) && (age_q[0] == AGE_MAX);

endmodule

// File: rtl/sbc_fwd_timer.sv
`timescale 1ns/1ps
// Forward window: high for SLOT_TIME cycles after each start.
module sbc_fwd_timer #(
  parameter int unsigned SLOT_TIME = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic active_o
);

  localparam int unsigned CW = sbc_pkg::cnt_width(SLOT_TIME);
  localparam logic [CW-1:0] LOAD = CW'(SLOT_TIME);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = fire_i || (cnt_q != '0);
    if (fire_i) begin
      cnt_d = LOAD;
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = (cnt_q != '0);

endmodule

// File: rtl/slot_buf_ctrl.sv
`timescale 1ns/1ps
module slot_buf_ctrl #(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned SLOT_TIME = 8,
  parameter int unsigned MODULES   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sop_i,
  input  logic               eop_i,
  input  logic [MODULES-2:0] peer_busy_i,
  output logic [SLOTS:0]     store_o,
  output logic               fwd_o,
  output logic               busy_o
);

  logic [SLOTS:0] ptr;
  logic [SLOTS:0] ptr_next;
  logic           head_ready;
  logic           fwd_active;
  logic           fwd_fire;
  logic           arrive;

  // Arrival event from the start-of-packet pulse; eop_i is not used.
  assign arrive   = sop_i;
  assign fwd_fire = head_ready && !fwd_active && !(|peer_busy_i);

  sbc_store_ptr #(.SLOTS(SLOTS)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .arrive_i   (arrive),
    .depart_i   (fwd_fire),
    .ptr_o      (ptr),
    .ptr_next_o (ptr_next)
  );

  sbc_age_track #(.SLOTS(SLOTS), .SLOT_TIME(SLOT_TIME)) u_age (
    .clk          (clk),
    .rst_n        (rst_n),
    .arrive_i     (arrive),
    .depart_i     (fwd_fire),
    .ptr_i        (ptr),
    .ptr_next_i   (ptr_next),
    .head_ready_o (head_ready)
  );

  sbc_fwd_timer #(.SLOT_TIME(SLOT_TIME)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (fwd_fire),
    .active_o (fwd_active)
  );

  assign store_o = ptr;
  assign fwd_o   = fwd_active;
  assign busy_o  = fwd_active;

endmodule

// File: rtl/slot_buf_ctrl_chk.sv
`timescale 1ns/1ps
module slot_buf_ctrl_chk #(
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned SLOT_TIME = 8,
  parameter int unsigned MODULES   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sop_i,
  input logic               eop_i,
  input logic [MODULES-2:0] peer_busy_i,
  input logic               fwd_fire,
  input logic [SLOTS:0]     store_o,
  input logic               fwd_o
);

  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= 0;
    end else if (fwd_o) begin
      run_len <= run_len + 1;
    end else begin
      run_len <= 0;
    end
  end

  p_store_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_o));

  p_arrive_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i && !fwd_fire && (store_o == '0) |=> store_o == (SLOTS+1)'(1));

  p_top_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i && !fwd_fire && store_o[SLOTS] |=> store_o[SLOTS]);

  p_fwd_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_fire && !sop_i |=> store_o == ($past(store_o) >> 1));

  p_fwd_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_fire |=> fwd_o);

  p_fwd_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fwd_o) |-> run_len == SLOT_TIME);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> !fwd_fire);

  p_peer_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|peer_busy_i) |-> !fwd_fire);

  p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i && fwd_fire |=> $stable(store_o));

  p_eop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eop_i && !sop_i && !fwd_fire |=> $stable(store_o));

endmodule

bind slot_buf_ctrl slot_buf_ctrl_chk #(
  .SLOTS(SLOTS), .SLOT_TIME(SLOT_TIME), .MODULES(MODULES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sop_i       (sop_i),
  .eop_i       (eop_i),
  .peer_busy_i (peer_busy_i),
  .fwd_fire    (fwd_fire),
  .store_o     (store_o),
  .fwd_o       (fwd_o)
);

// File: tb/test_slot_buf_ctrl.sv
`timescale 1ns/1ps
module test_slot_buf_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int S  = 3;
  localparam int ST = 6;
  localparam int NM = 3;

  logic          clk;
  logic          rst_n;
  logic          sop;
  logic          eop;
  logic [NM-2:0] peer;
  logic [S:0]    store_o;
  logic          fwd_o;
  logic          busy_o;

  int cyc;
  int n_checks;
  int n_errors;
  bit done;

  typedef struct {
    int         cyc;
    logic [S:0] store;
    logic       fwd;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  slot_buf_ctrl #(.SLOTS(S), .SLOT_TIME(ST), .MODULES(NM)) i_slot_buf_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sop_i       (sop),
    .eop_i       (eop),
    .peer_busy_i (peer),
    .store_o     (store_o),
    .fwd_o       (fwd_o),
    .busy_o      (busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Reference model built from the requirements; pushes one expected item per edge.
  int  m_lvl;
  int  m_age[S];
  int  m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0;
      m_cnt = 0;
      for (int k = 0; k < S; k++) m_age[k] = 0;
      exp_q.delete();
    end else begin
      bit    fire;
      bit    c1;
      int    nl;
      exp_t  it;
      string tg;
      c1   = sop;
      fire = (m_lvl >= 1) && (m_age[0] == ST) && (m_cnt == 0) && (peer == '0);
      nl   = m_lvl;
      if (c1 && !fire) nl = (m_lvl == S + 1) ? m_lvl : m_lvl + 1;
      if (fire && !c1) nl = m_lvl - 1;
      if (fire) begin
        for (int k = 0; k < S - 1; k++) m_age[k] = m_age[k+1];
        m_age[S-1] = 0;
      end
      for (int k = 0; k < S; k++) begin
        if (k >= ((nl < S) ? nl : S)) m_age[k] = 0;
        else if (c1 && (nl == k + 1)) m_age[k] = 0;
        else if (m_age[k] < ST) m_age[k] = m_age[k] + 1;
      end
      m_lvl = nl;
      if (fire) m_cnt = ST;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      tg = (c1 && fire) ? "R9" : fire ? "R4" : c1 ? "R3" : "R6";
      it.cyc   = cyc + 1;
      it.store = (m_lvl == 0) ? '0 : ((S+1)'(1) << (m_lvl - 1));
      it.fwd   = (m_cnt != 0);
      it.tag   = tg;
      exp_q.push_back(it);
    end
  end

  // Monitor: compares each edge's outputs against the queued expectation.
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(it.cyc == cyc, "R2 queue alignment", it.cyc, cyc);
      check(store_o === it.store, it.tag, int'(store_o), int'(it.store));
      check(fwd_o === it.fwd, (it.tag == "R6") ? "R6" : "R5", int'(fwd_o), int'(it.fwd));
      check(busy_o === fwd_o, "R7", int'(busy_o), int'(fwd_o));
      check($countones(store_o) <= 1, "R2", $countones(store_o), 1);
    end
  end

  task automatic pulse_sop(output int e);
    @(negedge clk);
    sop = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    sop = 1'b0;
  endtask

  task automatic wait_level(input logic lvl, output int c);
    int guard;
    guard = 0;
    do begin
      @(posedge clk);
      #2;
      guard++;
    end while (fwd_o !== lvl && guard < 2000);
    c = cyc;
  endtask

  task automatic wait_empty();
    int guard;
    guard = 0;
    while ((store_o != '0 || fwd_o) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int e;
    int c;
    int f;
    int er;
    cyc = 0; n_checks = 0; n_errors = 0;
    sop = 0; eop = 0; peer = '0;
    rst_n = 1'b0;
    sop = 1'b1;
    repeat (3) @(negedge clk);
    check(store_o == '0, "R1 store", int'(store_o), 0);
    check(!fwd_o && !busy_o, "R1 fwd", int'(fwd_o), 0);
    sop = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 / R6 / R4: single packet timing
    pulse_sop(e);
    check(store_o == 4'b0001, "R3 first", int'(store_o), 1);
    wait_level(1'b1, c);
    check(c == e + ST + 1, "R5 start", c, e + ST + 1);
    check(store_o == '0, "R4 to empty", int'(store_o), 0);
    wait_level(1'b0, f);
    check(f - c == ST, "R6 length", f - c, ST);
    wait_empty();

    // R3 / R8 / R11: fill past discard while a peer holds the output
    @(negedge clk);
    peer = 2'b10;
    for (int i = 0; i < S + 2; i++) pulse_sop(e);
    check(store_o == (4'b0001 << S), "R3 saturate", int'(store_o), 1 << S);
    repeat (15) @(negedge clk);
    check(fwd_o == 1'b0, "R8 held", int'(fwd_o), 0);
    check(store_o == (4'b0001 << S), "R8 store held", int'(store_o), 1 << S);
    peer = 2'b00;
    er = cyc + 1;
    wait_level(1'b1, c);
    check(c == er, "R8 retry", c, er);
    check(store_o == (4'b0001 << (S - 1)), "R4 down", int'(store_o), 1 << (S - 1));
    wait_level(1'b0, f);
    wait_level(1'b1, c);
    check(c == f + 1, "R11 back to back", c, f + 1);
    wait_empty();

    // R9: arrival on the same edge as a forward start
    @(negedge clk);
    peer = 2'b01;
    pulse_sop(e);
    repeat (ST + 6) @(negedge clk);
    peer = 2'b00;
    sop = 1'b1;
    @(negedge clk);
    sop = 1'b0;
    check(store_o == 4'b0001, "R9 store", int'(store_o), 1);
    check(fwd_o == 1'b1, "R9 fwd", int'(fwd_o), 1);
    wait_empty();

    // R10: end-of-packet pulses change nothing
    pulse_sop(e);
    for (int i = 0; i < 3; i++) begin
      eop = 1'b1;
      @(negedge clk);
      eop = 1'b0;
    end
    check(store_o == 4'b0001, "R10 store", int'(store_o), 1);
    check(fwd_o == 1'b0, "R10 fwd", int'(fwd_o), 0);
    wait_level(1'b1, c);
    check(c == e + ST + 1, "R10 timing", c, e + ST + 1);
    wait_empty();

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      sop = ($urandom_range(0, 9) == 0) && !sop;
      eop = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) peer = NM'($urandom_range(0, 3));
    end
    @(negedge clk);
    sop = 0; eop = 0; peer = '0;

    // R1: reset in the middle of traffic
    pulse_sop(e);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(store_o == '0, "R1 mid store", int'(store_o), 0);
    check(!fwd_o && !busy_o, "R1 mid fwd", int'(busy_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(store_o == '0, "R1 after", int'(store_o), 0);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule